// File: doc/BRIEF.md
# Indirect Subsystem Register Bridge

This bridge lets a host with a 32-bit register window reach an 8-bit register space that lives in a slow, always-on timekeeping domain. Internal registers have no direct host addresses. To reach one, the host writes a command word that holds the internal address, the transfer direction, a size bit and two groups of byte-lane enables. It then polls a busy bit in that same word and moves data through a lower data register. The slow-domain access is modelled as a fixed number of cycles during which the internal address and write data are held steady. A one-cycle read or write strobe marks the start of each access.

For a read, the host writes the command word with the direction bit set, waits for busy to clear, and takes the byte from the lower data register. The byte lands in the lane picked by the lowest set lower enable. For a write, the host first writes the command word with the direction bit clear. Writing the lower data register then launches the access, and the byte comes from the selected lane. The bridge also holds a two-bit interrupt enable register and a write-one-to-clear flag register. Flag bit 1 records subsystem events and flag bit 0 records completed interface transfers. A single interrupt line is driven from the enabled flags.

Top module: `ssbridge_top`

## Requirements
- R1: After reset, busy is 0, the enable and flag registers read 0, irq is 0, offset 0x00 returns the ID_VALUE parameter, and offset 0x0C (upper data) always reads 0.
- R2: Command word readback at 0x04 is: bit 31 busy (read-only), bit 25 size, bit 24 direction (1 = read), bits 23:20 upper enables, bits 19:16 lower enables, bits 7:0 internal address. All other bits read 0.
- R3: A command write with direction 1 and at least one lower enable set starts an internal read. ib_rd pulses for one cycle in the cycle after the write. Busy then stays 1 for exactly LATENCY cycles, and the byte on ib_rdata is captured when busy ends.
- R4: A command write with direction 0 and a lower enable set arms a write. The next lower data write (offset 0x08) launches it: ib_wr pulses for one cycle in the following cycle, and busy lasts LATENCY cycles.
- R5: The lowest set bit k of the lower enables selects byte lane k, which is bits 8k+7:8k of the lower data register. A read replaces only that lane, and a write sends that lane's byte. If no lower enable is set, no access starts.
- R6: Command and lower data writes that arrive while busy is 1 are ignored.
- R7: A lower data write with no armed write only stores the value and produces no strobe.
- R8: A rising edge of ss_event sets flag bit 1. Holding ss_event high does not set the flag again after it is cleared.
- R9: The end of every internal transfer sets flag bit 0.
- R10: Writing 1 to a flag bit at 0x14 clears it. A set arriving in the same cycle wins over the clear.
- R11: irq is 1 exactly when some flag bit and its enable bit (offset 0x10, bits 1:0) are both 1.
- R12: ib_rd and ib_wr are never both 1, and ib_addr and ib_wdata do not change while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 6 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr (combinational) |
| ib_addr | output | 8 | Internal register address |
| ib_wdata | output | 8 | Internal write byte |
| ib_wr | output | 1 | Internal write strobe |
| ib_rd | output | 1 | Internal read strobe |
| ib_rdata | input | 8 | Internal read byte |
| ss_event | input | 1 | Subsystem event level |
| irq | output | 1 | Interrupt request |

## Verification
Some rules are checked by assertions on every cycle. These cover strobe exclusivity and the single-cycle strobe shape, the start of every busy window, the internal address and data holding steady through a transfer, command writes being dropped while busy, and the flag set and clear behaviour. Other behaviour can only be shown through the bench's scenarios, which compare results against a shadow copy of the subsystem registers. That includes the exact busy length, which lane is picked when several enables are set, lane merging on reads, write data reaching the subsystem, events held high not re-triggering, and a set landing in the same cycle as a clear.

// File: rtl/ssbridge_pkg.sv
package ssbridge_pkg;
    localparam int unsigned REG_AW = 8;
    localparam int unsigned HOST_DW = 32;
    localparam int unsigned NLANES = HOST_DW / 8;

    typedef enum logic [3:0] {
        OFS_ID    = 4'd0,
        OFS_CMD   = 4'd1,
        OFS_LDATA = 4'd2,
        OFS_UDATA = 4'd3,
        OFS_IEN   = 4'd4,
        OFS_IFLG  = 4'd5
    } ofs_e;

    typedef struct packed {
        logic              size;
        logic              dir;
        logic [3:0]        ben_u;
        logic [3:0]        ben_l;
        logic [REG_AW-1:0] addr;
    } cmd_t;
endpackage

// File: rtl/ssbridge_lane_pick.sv
module ssbridge_lane_pick #(
    parameter int LANES = 4,
    localparam int IW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0] ben,
    output logic             vld,
    output logic [IW-1:0]    idx
);
    always_comb begin
        vld = |ben;
        idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (ben[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/ssbridge_irq_flags.sv
module ssbridge_irq_flags #(
    parameter int NF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    input  logic [NF-1:0] en,
    output logic [NF-1:0] flags,
    output logic          irq
);
    logic [NF-1:0] flg_d, flg_q;

    always_comb begin
        flg_d = (flg_q & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign flags = flg_q;
    assign irq   = |(flg_q & en);

    generate
        for (genvar g = 0; g < NF; g++) begin : g_chk
            p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
                set[g] |=> flags[g]);
            p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[g] && !set[g]) |=> !flags[g]);
        end
    endgenerate
endmodule

// File: rtl/ssbridge_top.sv
module ssbridge_top
    import ssbridge_pkg::*;
#(
    parameter int          LATENCY  = 4,
    parameter logic [31:0] ID_VALUE = 32'h4B52_0103
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [5:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic [REG_AW-1:0] ib_addr,
    output logic [7:0]        ib_wdata,
    output logic              ib_wr,
    output logic              ib_rd,
    input  logic [7:0]        ib_rdata,
    input  logic              ss_event,
    output logic              irq
);
    localparam int CW = $clog2(LATENCY + 1);
    localparam int LW = $clog2(NLANES);

    typedef struct packed {
        cmd_t          cmd;
        logic [31:0]   ldata;
        logic [1:0]    ien;
        logic [CW-1:0] cnt;
        logic          op_rd;
        logic          pend_wr;
        logic [7:0]    wbyte;
        logic [LW-1:0] lane;
        logic          evt;
    } st_t;

    st_t st_d, st_q;

    logic [3:0]    ofs;
    logic          busy, cmd_wr, ld_wr, done;
    logic          new_vld, cur_vld;
    logic [LW-1:0] new_idx, cur_idx;
    cmd_t          new_cmd;
    logic [1:0]    flg_set, flg_clr, flags;
    logic          unused_bits;

    assign ofs      = host_addr[5:2];
    assign busy     = st_q.cnt != '0;
    assign cmd_wr   = host_we && (ofs == OFS_CMD) && !busy;
    assign ld_wr    = host_we && (ofs == OFS_LDATA) && !busy;
    assign done     = st_q.cnt == CW'(1);
    assign new_cmd  = '{size: host_wdata[25], dir: host_wdata[24], ben_u: host_wdata[23:20],
                        ben_l: host_wdata[19:16], addr: host_wdata[REG_AW-1:0]};
    assign unused_bits = ^{host_wdata[30:26], host_wdata[15:REG_AW], host_addr[1:0]};

    ssbridge_lane_pick #(.LANES(NLANES)) u_pick_new (
        .ben(new_cmd.ben_l), .vld(new_vld), .idx(new_idx));
    ssbridge_lane_pick #(.LANES(NLANES)) u_pick_cur (
        .ben(st_q.cmd.ben_l), .vld(cur_vld), .idx(cur_idx));

    always_comb begin
        st_d     = st_q;
        st_d.evt = ss_event;
        if (busy) begin
            st_d.cnt = st_q.cnt - CW'(1);
            if (done && st_q.op_rd) st_d.ldata[{st_q.lane, 3'b000} +: 8] = ib_rdata;
        end
        if (cmd_wr) begin
            st_d.cmd     = new_cmd;
            st_d.pend_wr = !new_cmd.dir && new_vld;
            if (new_cmd.dir && new_vld) begin
                st_d.cnt   = CW'(LATENCY);
                st_d.op_rd = 1'b1;
                st_d.lane  = new_idx;
            end
        end
        if (ld_wr) begin
            st_d.ldata = host_wdata;
            if (st_q.pend_wr && cur_vld) begin
                st_d.cnt     = CW'(LATENCY);
                st_d.op_rd   = 1'b0;
                st_d.lane    = cur_idx;
                st_d.wbyte   = host_wdata[{cur_idx, 3'b000} +: 8];
                st_d.pend_wr = 1'b0;
            end
        end
        if (host_we && ofs == OFS_IEN) st_d.ien = host_wdata[1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flg_set = {ss_event && !st_q.evt, done};
    assign flg_clr = (host_we && ofs == OFS_IFLG) ? host_wdata[1:0] : 2'b00;

    ssbridge_irq_flags #(.NF(2)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(flg_set), .clr(flg_clr),
        .en(st_q.ien), .flags(flags), .irq(irq));

    assign ib_addr  = st_q.cmd.addr;
    assign ib_wdata = st_q.wbyte;
    assign ib_rd    = (st_q.cnt == CW'(LATENCY)) && st_q.op_rd;
    assign ib_wr    = (st_q.cnt == CW'(LATENCY)) && !st_q.op_rd;

    always_comb begin
        host_rdata = '0;
        case (ofs)
            OFS_ID:    host_rdata = ID_VALUE;
            OFS_CMD:   host_rdata = {busy, 5'b0, st_q.cmd.size, st_q.cmd.dir, st_q.cmd.ben_u,
                                     st_q.cmd.ben_l, {(16 - REG_AW){1'b0}}, st_q.cmd.addr};
            OFS_LDATA: host_rdata = st_q.ldata;
            OFS_IEN:   host_rdata = {30'b0, st_q.ien};
            OFS_IFLG:  host_rdata = {30'b0, flags};
            default:   host_rdata = '0;
        endcase
    end

    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(ib_rd && ib_wr));
    p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_rd || ib_wr) |=> !(ib_rd || ib_wr));
    p_busy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (ib_rd || ib_wr));
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(ib_addr) && $stable(ib_wdata)));
    p_ignore_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && busy && (ofs == OFS_CMD || ofs == OFS_LDATA)) |=> $stable(ib_addr));
endmodule

// File: tb/ssbridge_top_tb_top.sv
module ssbridge_top_tb_top;
    localparam int LAT = 4;
    localparam logic [31:0] IDV = 32'h4B52_0103;
    localparam logic [5:0] A_ID = 6'h00, A_CMD = 6'h04, A_LD = 6'h08, A_UD = 6'h0C,
                           A_IEN = 6'h10, A_FLG = 6'h14;

    logic clk = 1'b0, rst_n = 1'b0, host_we = 1'b0, ss_event = 1'b0;
    logic [5:0] host_addr = '0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic [7:0] ib_addr, ib_wdata, ib_rdata;
    logic ib_wr, ib_rd, irq;

    int errors = 0, checks = 0, cyc = 0, wr_strobes = 0;
    logic [7:0] mem [256];
    logic [7:0] shadow [256];
    logic [7:0] last_wr_addr;

    always #2 clk = ~clk;

    ssbridge_top #(.LATENCY(LAT), .ID_VALUE(IDV)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .ib_addr(ib_addr),
        .ib_wdata(ib_wdata), .ib_wr(ib_wr), .ib_rd(ib_rd), .ib_rdata(ib_rdata),
        .ss_event(ss_event), .irq(irq));

    assign ib_rdata = mem[ib_addr];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ib_wr) begin
            mem[ib_addr] <= ib_wdata;
            wr_strobes <= wr_strobes + 1;
            last_wr_addr <= ib_addr;
        end
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) if (cyc > 150000) begin
        errors = errors + 1;
        $display("FAIL watchdog: run hung");
        report();
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cmd_view(logic [31:0] w);
        return w & 32'h03FF_00FF;
    endfunction

    function automatic int low_lane(logic [3:0] b);
        for (int i = 0; i < 4; i++) if (b[i]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] merge(logic [31:0] w, int lane, logic [7:0] b);
        logic [31:0] r = w;
        r[lane*8 +: 8] = b;
        return r;
    endfunction

    task automatic hwrite(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #0.5 d = host_rdata;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        host_addr = A_CMD;
        #0.5;
        while (host_rdata[31] && n < 100) begin
            n++;
            @(negedge clk);
            host_addr = A_CMD;
            #0.5;
        end
    endtask

    logic [31:0] r, pre;
    int n, ws;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i) ^ 8'h3C;
            shadow[i] = 8'(i) ^ 8'h3C;
        end
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        hread(A_CMD, r); chk("R1 busy", {31'b0, r[31]}, 0);
        hread(A_ID, r);  chk("R1 id", r, IDV);
        hread(A_UD, r);  chk("R1 udata", r, 0);
        hread(A_IEN, r); chk("R1 ien", r, 0);
        hread(A_FLG, r); chk("R1 flags", r, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R2 layout, R5 no enable no access
        hwrite(A_CMD, 32'hFFF0_FFAB);
        hread(A_CMD, r); chk("R2 cmd readback", r, cmd_view(32'hFFF0_FFAB));
        hwrite(A_CMD, 32'h0130_0011);
        hread(A_CMD, r); chk("R5 no enable no busy", r, cmd_view(32'h0130_0011));
        hwrite(A_LD, 32'h1111_2222);
        chk("R7 no strobe without arm", wr_strobes, 0);

        // random write/read round trips
        for (int it = 0; it < 24; it++) begin
            logic [7:0] a = 8'($urandom);
            logic [7:0] v = 8'($urandom);
            logic [3:0] be = 4'($urandom) | 4'b0001 << ($urandom % 4);
            logic [3:0] be2 = 4'($urandom) | 4'b1000;
            int k = low_lane(be), j = low_lane(be2);
            logic [31:0] w = merge($urandom, k, v);
            ws = wr_strobes;
            hwrite(A_CMD, {8'h00, 4'($urandom), be, 8'h00, a});
            hwrite(A_LD, w);
            shadow[a] = v;
            wait_idle(n);
            chk("R4 write busy length", n, LAT);
            chk("R4 one strobe", wr_strobes - ws, 1);
            chk("R5 write lane byte", {24'b0, mem[a]}, {24'b0, v});
            chk("R12 address at strobe", {24'b0, last_wr_addr}, {24'b0, a});
            pre = $urandom;
            hwrite(A_LD, pre);
            hwrite(A_CMD, {8'h01, 4'h0, be2, 8'h00, a});
            wait_idle(n);
            chk("R3 read busy length", n, LAT);
            hread(A_LD, r);
            chk("R3 R5 read lane merge", r, merge(pre, j, shadow[a]));
        end

        // R6 writes while busy ignored
        hwrite(A_LD, 32'hAAAA_AAAA);
        hwrite(A_CMD, 32'h0101_0042);
        ws = wr_strobes;
        hwrite(A_CMD, 32'h0002_0077);
        hwrite(A_LD, 32'h5555_5555);
        wait_idle(n);
        hread(A_CMD, r); chk("R6 cmd kept", r, cmd_view(32'h0101_0042));
        hread(A_LD, r);  chk("R6 ldata kept", r, merge(32'hAAAA_AAAA, 0, shadow[8'h42]));
        chk("R6 no write strobe", wr_strobes - ws, 0);

        // R9 / R10 / R11 flags
        hread(A_FLG, r); chk("R9 done flag", r, 32'h1);
        hwrite(A_IEN, 32'h1);
        chk("R11 irq on done", {31'b0, irq}, 1);
        hwrite(A_FLG, 32'h1);
        hread(A_FLG, r); chk("R10 clear", r, 0);
        chk("R11 irq low", {31'b0, irq}, 0);

        @(negedge clk); ss_event = 1'b1;
        @(negedge clk);
        hread(A_FLG, r); chk("R8 event sets bit1", r, 32'h2);
        chk("R11 bit1 masked", {31'b0, irq}, 0);
        hwrite(A_IEN, 32'h2);
        chk("R11 bit1 enabled", {31'b0, irq}, 1);
        hwrite(A_FLG, 32'h2);
        repeat (3) @(negedge clk);
        hread(A_FLG, r); chk("R8 level no retrigger", r, 0);
        ss_event = 1'b0;
        @(negedge clk);
        // R10 set wins over same-cycle clear
        host_we = 1'b1; host_addr = A_FLG; host_wdata = 32'h2; ss_event = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
        hread(A_FLG, r); chk("R10 set wins", r, 32'h2);
        report();
    end
endmodule